// File: doc/BRIEF.md
# DMA Channel Request and Transfer Sequencer

This block is the control side of a single DMA channel. A request can come from one of three places. The first is an auto-request, which is always asserted. The second is an on-chip peripheral request line. The third is an external request pin, which can be sensed as a low level, a high level, a falling edge or a rising edge. When a request is valid, the block asks for the bus. Once the bus is granted, it runs one transfer unit, which is made of one or more bus cycles of the programmed size, and counts the unit against a loaded transfer count. A bus cycle is finished when the bus side pulses `cyc_done`.

In cycle-steal mode the block gives the bus back after every unit. In burst mode it keeps the bus from one unit to the next. A 16-byte unit always runs as four longword cycles without releasing the bus. When the last unit of the count completes, an end flag is set and no further requests are taken. The flag stays set until software clears it through the control write port. An interrupt output follows the end flag when the interrupt-enable bit is set. Address generation, the data path and arbitration between channels belong to neighbouring blocks.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, every control field, the transfer count, the end flag, `irq_o`, `bus_req_o` and `cfg_rdata_o` are all 0.
- R2: With the pin source selected, the detect field is decoded as follows: 00 = request while the pin is low, 01 = one request per falling edge, 10 = request while the pin is high, 11 = one request per rising edge. The pin passes through two synchroniser flops before it is used.
- R3: In an edge mode, each detected edge latches one pending request. The pending request is cleared when the bus grant starts the unit it requested.
- R4: With the auto source (00) or the peripheral source (01), the detect field and the pin have no effect on requests.
- R5: When `HAS_PIN` is 0, the detect field always reads back as 0, and the pin source (10) never produces a request.
- R6: The size field is decoded as 00 byte, 01 word, 10 longword and 11 16-byte unit. The `cyc_size_o` output shows the size of each bus cycle. A 16-byte unit is issued as four cycles of size 10.
- R7: In cycle-steal mode (burst bit 0), `bus_req_o` is low for at least one cycle after each unit ends.
- R8: In burst mode (burst bit 1), `bus_req_o` stays high from one unit to the next. The bus is released when the count reaches zero. In a level mode or with the peripheral source, it is also released when the request is withdrawn at the end of a unit.
- R9: The count decreases by one for each completed unit. When the last unit completes, the end flag is set, and requests are then ignored until the flag is cleared.
- R10: A 16-byte unit is never split by a bus release, in either bus mode.
- R11: `irq_o` is high exactly while the end flag is 1 and the interrupt-enable bit is 1.
- R12: The control word layout is: [1:0] size, [2] burst, [3] interrupt enable, [5:4] detect, [7:6] source (00 auto, 01 peripheral, 10 pin, 11 none). `cfg_rdata_o` returns these fields. Writing 1 to write bit 8 clears the end flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 9 | Control word; bit 8 clears the end flag |
| cfg_rdata_o | output | 8 | Current control fields |
| cnt_load_i | input | 1 | Load the transfer count |
| cnt_value_i | input | CNT_W | Transfer count in units |
| req_pin_i | input | 1 | External request pin (asynchronous) |
| req_periph_i | input | 1 | On-chip peripheral request level |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| cyc_done_i | input | 1 | Current bus cycle finished |
| xfer_act_o | output | 1 | A transfer unit is in progress on the bus |
| cyc_size_o | output | 2 | Size code of the current bus cycle |
| cnt_left_o | output | CNT_W | Units remaining |
| end_flag_o | output | 1 | Transfer-end flag |
| irq_o | output | 1 | Transfer-end interrupt request |

## Verification
Several properties are checked on every cycle:
- the bus is released after a cycle-steal unit;
- the bus is not released in the middle of a 16-byte unit;
- no bus cycle carries the 16-byte code;
- the end flag rises when the final unit completes;
- a latched edge request is not lost before its unit starts;
- a disarmed channel does not request the bus.

Other behaviours can only be shown by the bench's scenarios: that each of the four pin detection modes is decoded correctly, that the pin is ignored under the other sources, the burst-stop point when a level request goes away, and the read-back masking on a channel without a pin. A behavioural model in the bench follows all of these cycle by cycle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      SRC_AUTO   = 2'b00,
      SRC_PERIPH = 2'b01,
      SRC_PIN    = 2'b10,
      SRC_NONE   = 2'b11
   } src_e;

   typedef enum logic [1:0] {
      DET_LOW  = 2'b00,
      DET_FALL = 2'b01,
      DET_HIGH = 2'b10,
      DET_RISE = 2'b11
   } det_e;

   typedef enum logic [1:0] {
      SZ_BYTE   = 2'b00,
      SZ_WORD   = 2'b01,
      SZ_LONG   = 2'b10,
      SZ_UNIT16 = 2'b11
   } size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_REQ  = 2'b01,
      ST_XFER = 2'b10
   } state_e;

   // packed so that the bit layout equals the control word [7:0]
   typedef struct packed {
      src_e  src;
      det_e  det;
      logic  ie;
      logic  burst;
      size_e size;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/dma_req_detect.sv
module dma_req_detect
   import dma_seq_pkg::*;
#(
   parameter int HAS_PIN     = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  req_pin_i,
   input  logic  req_periph_i,
   input  src_e  src_i,
   input  det_e  det_i,
   input  logic  end_flag_i,
   input  logic  cfg_we_i,
   input  logic  unit_start_i,
   output logic  req_valid_o,
   output logic  one_shot_o
);

   logic pin_req;
   logic pin_one_shot;

   generate
      if (HAS_PIN != 0) begin : g_pin
         logic [SYNC_STAGES-1:0] sync_q;
         logic                   dly_q;
         logic                   pend_q;
         logic                   lvl;
         logic                   rise_hit;
         logic                   fall_hit;
         logic                   edge_hit;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               sync_q <= '0;
               dly_q  <= 1'b0;
            end else begin
               sync_q <= {sync_q[SYNC_STAGES-2:0], req_pin_i};
               dly_q  <= sync_q[SYNC_STAGES-1];
            end
         end

         assign lvl      = sync_q[SYNC_STAGES-1];
         assign rise_hit = lvl & ~dly_q;
         assign fall_hit = ~lvl & dly_q;
         assign edge_hit = (src_i == SRC_PIN) && !end_flag_i &&
                           (((det_i == DET_RISE) && rise_hit) ||
                            ((det_i == DET_FALL) && fall_hit));

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               pend_q <= 1'b0;
            end else if (cfg_we_i) begin
               pend_q <= 1'b0;
            end else if (edge_hit) begin
               pend_q <= 1'b1;
            end else if (unit_start_i) begin
               pend_q <= 1'b0;
            end
         end

         always_comb begin
            unique case (det_i)
               DET_LOW:  pin_req = ~lvl;
               DET_HIGH: pin_req = lvl;
               default:  pin_req = pend_q;
            endcase
         end

         assign pin_one_shot = det_i[0];

         // R3: a latched edge survives until its unit starts or a rewrite
         a_r3_pend_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (pend_q && !unit_start_i && !cfg_we_i) |=> pend_q);
      end else begin : g_nopin
         logic unused_pin;
         assign unused_pin   = ^{req_pin_i, det_i, end_flag_i, cfg_we_i, unit_start_i};
         assign pin_req      = 1'b0;
         assign pin_one_shot = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (src_i)
         SRC_AUTO:   req_valid_o = 1'b1;
         SRC_PERIPH: req_valid_o = req_periph_i;
         SRC_PIN:    req_valid_o = pin_req;
         default:    req_valid_o = 1'b0;
      endcase
   end

   assign one_shot_o = (src_i == SRC_AUTO) || ((src_i == SRC_PIN) && pin_one_shot);

endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cnt_load_i,
   input  logic [CNT_W-1:0] cnt_value_i,
   input  logic             unit_done_i,
   input  logic             end_clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             end_o,
   output logic             last_unit_o,
   output logic             armed_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             end_q;
   logic             end_set;

   assign last_unit_o = (cnt_q == CNT_W'(1));
   assign end_set     = unit_done_i && last_unit_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (cnt_load_i) begin
         cnt_q <= cnt_value_i;
      end else if (unit_done_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         end_q <= 1'b0;
      end else if (end_set) begin
         end_q <= 1'b1;
      end else if (end_clr_i) begin
         end_q <= 1'b0;
      end
   end

   assign cnt_o   = cnt_q;
   assign end_o   = end_q;
   assign armed_o = (cnt_q != '0) && !end_q;

   // R9: finishing the final unit raises the end flag
   a_r9_end_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unit_done_i && cnt_q == CNT_W'(1)) |=> end_q);

endmodule

// File: rtl/dma_unit_seq.sv
module dma_unit_seq
   import dma_seq_pkg::*;
#(
   parameter int UNIT_BEATS = 4
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  armed_i,
   input  logic  req_valid_i,
   input  logic  one_shot_i,
   input  logic  burst_i,
   input  size_e size_i,
   input  logic  last_unit_i,
   input  logic  bus_gnt_i,
   input  logic  cyc_done_i,
   output logic  bus_req_o,
   output logic  xfer_act_o,
   output size_e cyc_size_o,
   output logic  unit_start_o,
   output logic  unit_done_o
);

   localparam int BEAT_W = (UNIT_BEATS > 1) ? $clog2(UNIT_BEATS) : 1;
   localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(UNIT_BEATS - 1);

   state_e            state_q, state_d;
   logic [BEAT_W-1:0] beats_q, beats_d;
   logic [BEAT_W-1:0] first_beats;
   logic              keep_bus;

   assign first_beats = (size_i == SZ_UNIT16) ? LAST_IDX : '0;
   assign keep_bus    = burst_i && !last_unit_i && (one_shot_i || req_valid_i);

   always_comb begin
      state_d      = state_q;
      beats_d      = beats_q;
      unit_start_o = 1'b0;
      unit_done_o  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (armed_i && req_valid_i) state_d = ST_REQ;
         end
         ST_REQ: begin
            if (!armed_i) begin
               state_d = ST_IDLE;
            end else if (bus_gnt_i) begin
               state_d      = ST_XFER;
               beats_d      = first_beats;
               unit_start_o = 1'b1;
            end
         end
         ST_XFER: begin
            if (cyc_done_i) begin
               if (beats_q == '0) begin
                  unit_done_o = 1'b1;
                  if (keep_bus) begin
                     beats_d      = first_beats;
                     unit_start_o = 1'b1;
                  end else begin
                     state_d = ST_IDLE;
                  end
               end else begin
                  beats_d = beats_q - BEAT_W'(1);
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         beats_q <= '0;
      end else begin
         state_q <= state_d;
         beats_q <= beats_d;
      end
   end

   assign bus_req_o  = (state_q != ST_IDLE);
   assign xfer_act_o = (state_q == ST_XFER);
   assign cyc_size_o = (size_i == SZ_UNIT16) ? SZ_LONG : size_i;

   // R7: cycle-steal gives the bus back after every unit
   a_r7_steal_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unit_done_o && !burst_i) |=> (state_q == ST_IDLE));

   // R10: no release between the cycles of one unit
   a_r10_unit_intact: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_XFER && cyc_done_i && beats_q != '0) |=> (state_q == ST_XFER));

   // R6: a bus cycle never carries the 16-byte code
   a_r6_cycle_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_XFER) |-> (cyc_size_o != SZ_UNIT16));

   // R9: an ended or empty channel does not request the bus
   a_r9_quiet_disarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && !armed_i) |=> (state_q != ST_REQ));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int HAS_PIN     = 1,
   parameter int SYNC_STAGES = 2,
   parameter int UNIT_BEATS  = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cfg_we_i,
   input  logic [8:0]       cfg_wdata_i,
   output logic [7:0]       cfg_rdata_o,
   input  logic             cnt_load_i,
   input  logic [CNT_W-1:0] cnt_value_i,
   input  logic             req_pin_i,
   input  logic             req_periph_i,
   output logic             bus_req_o,
   input  logic             bus_gnt_i,
   input  logic             cyc_done_i,
   output logic             xfer_act_o,
   output logic [1:0]       cyc_size_o,
   output logic [CNT_W-1:0] cnt_left_o,
   output logic             end_flag_o,
   output logic             irq_o
);

   localparam int END_CLR_BIT = CTL_W;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("dma_chan_seq: CNT_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dma_chan_seq: SYNC_STAGES must be at least 2");
      end
      if (HAS_PIN != 0 && HAS_PIN != 1) begin : g_bad_pin
         $error("dma_chan_seq: HAS_PIN must be 0 or 1");
      end
      if (UNIT_BEATS != 4) begin : g_bad_beats
         $error("dma_chan_seq: a 16-byte unit needs UNIT_BEATS of 4");
      end
   endgenerate

   ctl_t        ctl_q;
   logic [7:0]  ctl_wr;
   logic        end_clr;
   logic        armed;
   logic        last_unit;
   logic        req_valid;
   logic        one_shot;
   logic        unit_start;
   logic        unit_done;
   size_e       cyc_size;

   generate
      if (HAS_PIN != 0) begin : g_ctl_pin
         assign ctl_wr = cfg_wdata_i[7:0];
      end else begin : g_ctl_nopin
         assign ctl_wr = {cfg_wdata_i[7:6], 2'b00, cfg_wdata_i[3:0]};
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctl_q <= '0;
      end else if (cfg_we_i) begin
         ctl_q <= ctl_t'(ctl_wr);
      end
   end

   assign end_clr = cfg_we_i && cfg_wdata_i[END_CLR_BIT];

   dma_req_detect #(
      .HAS_PIN     (HAS_PIN),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_detect (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_pin_i    (req_pin_i),
      .req_periph_i (req_periph_i),
      .src_i        (ctl_q.src),
      .det_i        (ctl_q.det),
      .end_flag_i   (end_flag_o),
      .cfg_we_i     (cfg_we_i),
      .unit_start_i (unit_start),
      .req_valid_o  (req_valid),
      .one_shot_o   (one_shot)
   );

   dma_xfer_count #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cnt_load_i  (cnt_load_i),
      .cnt_value_i (cnt_value_i),
      .unit_done_i (unit_done),
      .end_clr_i   (end_clr),
      .cnt_o       (cnt_left_o),
      .end_o       (end_flag_o),
      .last_unit_o (last_unit),
      .armed_o     (armed)
   );

   dma_unit_seq #(
      .UNIT_BEATS (UNIT_BEATS)
   ) u_seq (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .armed_i      (armed),
      .req_valid_i  (req_valid),
      .one_shot_i   (one_shot),
      .burst_i      (ctl_q.burst),
      .size_i       (ctl_q.size),
      .last_unit_i  (last_unit),
      .bus_gnt_i    (bus_gnt_i),
      .cyc_done_i   (cyc_done_i),
      .bus_req_o    (bus_req_o),
      .xfer_act_o   (xfer_act_o),
      .cyc_size_o   (cyc_size),
      .unit_start_o (unit_start),
      .unit_done_o  (unit_done)
   );

   assign cyc_size_o  = cyc_size;
   assign cfg_rdata_o = ctl_q;
   assign irq_o       = end_flag_o & ctl_q.ie;

endmodule

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;

   localparam int CLK_PERIOD = 10;
   localparam int CW         = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [8:0]    cfg_wdata = '0;
   logic [7:0]    cfg_rdata;
   logic          cnt_load = 1'b0;
   logic [CW-1:0] cnt_value = '0;
   logic          req_pin = 1'b0;
   logic          req_periph = 1'b0;
   logic          bus_req;
   logic          bus_gnt = 1'b0;
   logic          cyc_done = 1'b0;
   logic          xfer_act;
   logic [1:0]    cyc_size;
   logic [CW-1:0] cnt_left;
   logic          end_flag;
   logic          irq;

   // second channel without a request pin
   logic          cfg_we2 = 1'b0;
   logic [8:0]    cfg_wdata2 = '0;
   logic [7:0]    cfg_rdata2;
   logic          cnt_load2 = 1'b0;
   logic [CW-1:0] cnt_value2 = '0;
   logic          req_pin2 = 1'b0;
   logic          bus_req2;
   logic          xfer_act2;
   logic [1:0]    cyc_size2;
   logic [CW-1:0] cnt_left2;
   logic          end_flag2;
   logic          irq2;

   int n_chk = 0;
   int n_err = 0;
   int n_falls = 0;
   int n_done = 0;
   int n_long = 0;
   int n_req2 = 0;
   logic prev_req = 1'b0;
   logic mon_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_chan_seq #(.CNT_W(CW), .HAS_PIN(1)) i_dma_chan_seq (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
      .cfg_rdata_o(cfg_rdata), .cnt_load_i(cnt_load), .cnt_value_i(cnt_value),
      .req_pin_i(req_pin), .req_periph_i(req_periph), .bus_req_o(bus_req),
      .bus_gnt_i(bus_gnt), .cyc_done_i(cyc_done), .xfer_act_o(xfer_act),
      .cyc_size_o(cyc_size), .cnt_left_o(cnt_left), .end_flag_o(end_flag), .irq_o(irq));

   dma_chan_seq #(.CNT_W(CW), .HAS_PIN(0)) i_dma_chan_seq_nopin (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we2), .cfg_wdata_i(cfg_wdata2),
      .cfg_rdata_o(cfg_rdata2), .cnt_load_i(cnt_load2), .cnt_value_i(cnt_value2),
      .req_pin_i(req_pin2), .req_periph_i(1'b0), .bus_req_o(bus_req2),
      .bus_gnt_i(bus_req2), .cyc_done_i(xfer_act2), .xfer_act_o(xfer_act2),
      .cyc_size_o(cyc_size2), .cnt_left_o(cnt_left2), .end_flag_o(end_flag2), .irq_o(irq2));

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int       m_st;          // 0 idle, 1 asking, 2 moving
   int       m_beats;
   int       m_cnt;
   bit       m_end, m_pend;
   bit [2:0] m_sh;          // [0],[1] synchroniser, [2] delayed copy
   bit [1:0] m_src, m_det, m_size;
   bit       m_ie, m_burst;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_beats = 0; m_cnt = 0; m_end = 0; m_pend = 0; m_sh = '0;
         m_src = 0; m_det = 0; m_size = 0; m_ie = 0; m_burst = 0;
      end else begin
         bit rv, start, done, hit, armed, oneshot;
         int nst, nbeats;
         hit = (m_src == 2) && !m_end &&
               ((m_det == 1 && !m_sh[1] && m_sh[2]) || (m_det == 3 && m_sh[1] && !m_sh[2]));
         case (m_src)
            0: rv = 1;
            1: rv = req_periph;
            2: rv = (m_det == 0) ? !m_sh[1] : (m_det == 2) ? m_sh[1] : m_pend;
            default: rv = 0;
         endcase
         oneshot = (m_src == 0) || (m_src == 2 && m_det[0]);
         armed = (m_cnt != 0) && !m_end;
         start = 0; done = 0; nst = m_st; nbeats = m_beats;
         if (m_st == 0) begin
            if (armed && rv) nst = 1;
         end else if (m_st == 1) begin
            if (!armed) nst = 0;
            else if (bus_gnt) begin nst = 2; start = 1; nbeats = (m_size == 3) ? 3 : 0; end
         end else if (cyc_done) begin
            if (m_beats == 0) begin
               done = 1;
               if (m_burst && m_cnt != 1 && (oneshot || rv)) begin
                  start = 1; nbeats = (m_size == 3) ? 3 : 0;
               end else nst = 0;
            end else nbeats = m_beats - 1;
         end
         if (done && m_cnt == 1) m_end = 1;
         else if (cfg_we && cfg_wdata[8]) m_end = 0;
         if (cnt_load) m_cnt = cnt_value;
         else if (done && m_cnt != 0) m_cnt = m_cnt - 1;
         if (cfg_we) m_pend = 0;
         else if (hit) m_pend = 1;
         else if (start) m_pend = 0;
         if (cfg_we) {m_src, m_det, m_ie, m_burst, m_size} = cfg_wdata[7:0];
         m_sh = {m_sh[1], m_sh[0], req_pin};
         m_st = nst; m_beats = nbeats;
      end
   end

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (mon_on) begin
         chk("R7", "bus_req", bus_req, m_st != 0);
         chk("R10", "xfer_act", xfer_act, m_st == 2);
         chk("R6", "cyc_size", cyc_size, (m_size == 3) ? 2 : m_size);
         chk("R9", "cnt_left", cnt_left, m_cnt);
         chk("R9", "end_flag", end_flag, m_end);
         chk("R11", "irq", irq, m_end & m_ie);
         chk("R12", "cfg_rdata", cfg_rdata, {m_src, m_det, m_ie, m_burst, m_size});
         if (prev_req && !bus_req) n_falls++;
         prev_req = bus_req;
         if (bus_req2) n_req2++;
      end
   end

   // simple bus side: grant follows request, a cycle ends every other cycle
   always @(negedge clk) begin
      if (!rst_n) begin
         bus_gnt = 0; cyc_done = 0;
      end else begin
         bus_gnt  = bus_req;
         cyc_done = xfer_act && !cyc_done;
      end
   end

   always @(posedge clk) begin
      if (rst_n && cyc_done && xfer_act) begin
         n_done++;
         if (cyc_size == 2'b10) n_long++;
      end
   end

   task automatic cfg_wr(input bit [1:0] src, input bit [1:0] det, input bit ie,
                         input bit burst, input bit [1:0] size, input bit clr);
      @(negedge clk);
      cfg_we = 1; cfg_wdata = {clr, src, det, ie, burst, size};
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic load(input int n);
      @(negedge clk);
      cnt_load = 1; cnt_value = CW'(n);
      @(negedge clk);
      cnt_load = 0;
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr_counts();
      n_falls = 0; n_done = 0; n_long = 0;
   endtask

   task automatic pulse_pin(input int hi);
      @(negedge clk); req_pin = 1;
      waitc(hi);
      req_pin = 0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      waitc(3);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "reset bus_req", bus_req, 0);
      chk("R1", "reset cfg_rdata", cfg_rdata, 0);
      chk("R1", "reset end_flag", end_flag, 0);
      chk("R1", "reset cnt_left", cnt_left, 0);
      chk("R1", "reset irq", irq, 0);
      mon_on = 1;

      // auto source, cycle-steal, bytes, three units, interrupt enabled
      cfg_wr(2'b00, 2'b00, 1, 0, 2'b00, 0);
      clr_counts();
      load(3);
      waitc(60);
      chk("R7", "steal releases per unit", n_falls, 3);
      chk("R9", "units counted", n_done, 3);
      chk("R9", "end flag set", end_flag, 1);
      chk("R11", "irq with enable", irq, 1);
      waitc(20);
      chk("R9", "requests ignored after end", n_falls, 3);
      cfg_wr(2'b00, 2'b00, 1, 0, 2'b00, 1);
      chk("R12", "end flag cleared by bit 8", end_flag, 0);

      // auto burst longwords
      clr_counts();
      cfg_wr(2'b00, 2'b00, 0, 1, 2'b10, 1);
      load(4);
      waitc(60);
      chk("R8", "burst holds bus", n_falls, 1);
      chk("R8", "burst cycles", n_done, 4);
      chk("R6", "longword cycles", n_long, 4);

      // 16-byte units, cycle-steal
      clr_counts();
      cfg_wr(2'b00, 2'b00, 0, 0, 2'b11, 1);
      load(2);
      waitc(80);
      chk("R10", "four cycles per unit", n_done, 8);
      chk("R10", "one release per unit", n_falls, 2);
      chk("R6", "unit cycles are longword", n_long, 8);

      // rising edge on the pin
      req_pin = 0;
      cfg_wr(2'b10, 2'b11, 0, 0, 2'b00, 1);
      load(5);
      waitc(10);
      clr_counts();
      pulse_pin(3);
      waitc(30);
      pulse_pin(3);
      waitc(30);
      chk("R3", "one unit per rising edge", cnt_left, 3);
      chk("R2", "rising edge releases", n_falls, 2);

      // falling edge on the pin
      req_pin = 1;
      waitc(5);
      cfg_wr(2'b10, 2'b01, 0, 0, 2'b00, 1);
      load(5);
      waitc(10);
      clr_counts();
      chk("R2", "high pin no falling request", cnt_left, 5);
      req_pin = 0;
      waitc(30);
      chk("R2", "one unit on falling edge", cnt_left, 4);

      // high level, burst, request withdrawn
      cfg_wr(2'b10, 2'b10, 0, 1, 2'b00, 1);
      load(10);
      waitc(10);
      chk("R2", "low pin no high-level request", cnt_left, 10);
      clr_counts();
      req_pin = 1;
      waitc(8);
      req_pin = 0;
      waitc(40);
      chk("R8", "burst stops on withdrawal", (cnt_left > 0) && (cnt_left < 10), 1);
      chk("R8", "bus released", bus_req, 0);

      // low level
      req_pin = 1;
      waitc(5);
      cfg_wr(2'b10, 2'b00, 0, 0, 2'b01, 1);
      load(4);
      waitc(20);
      chk("R2", "high pin no low-level request", cnt_left, 4);
      req_pin = 0;
      waitc(40);
      chk("R2", "low level completes", end_flag, 1);

      // peripheral source ignores detect field and pin
      cfg_wr(2'b01, 2'b11, 0, 0, 2'b00, 1);
      load(3);
      req_periph = 0;
      pulse_pin(3); waitc(5);
      pulse_pin(3); waitc(20);
      chk("R4", "pin ignored under peripheral", cnt_left, 3);
      req_periph = 1;
      waitc(40);
      chk("R4", "peripheral request served", cnt_left, 0);
      chk("R11", "irq masked", irq, 0);
      chk("R11", "end set without irq", end_flag, 1);
      req_periph = 0;

      // read-back layout
      cfg_wr(2'b01, 2'b10, 1, 1, 2'b01, 0);
      chk("R12", "field layout", cfg_rdata, 8'h6D);

      // channel without pin
      @(negedge clk);
      cfg_we2 = 1; cfg_wdata2 = 9'h0B0;
      @(negedge clk);
      cfg_we2 = 0;
      chk("R5", "detect reads zero", cfg_rdata2, 8'h80);
      @(negedge clk);
      cnt_load2 = 1; cnt_value2 = CW'(2);
      @(negedge clk);
      cnt_load2 = 0;
      n_req2 = 0;
      req_pin2 = 1; waitc(5); req_pin2 = 0; waitc(20);
      chk("R5", "no pin request", n_req2, 0);
      chk("R5", "count untouched", cnt_left2, 2);

      mon_on = 0;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule